// File: doc/BRIEF.md
# Dual-IO SPI Flash Read Controller

This block sits on the host side of a serial flash and fetches bytes with the two-line fast read sequence. A user asks for a read by giving a start address and a byte count. The controller then runs one chip-select frame. That frame carries the read command, the address and a mode byte, followed by the data phase. The returned bytes come back one at a time, each marked by a single-cycle valid strobe. A done pulse closes every transaction.

The mode byte tells the flash whether the next frame may leave out the 8-clock command phase. When the caller sets `cont_en`, the controller sends the "stay" value and records in `cont_mode` that the flash now expects address-first frames. While that flag is set, later reads start sending the address on the first serial clock. A separate exit request runs a short frame that drives all-ones on both lines for 8 clocks, which takes the flash out of that mode.

The serial clock idles low. Outputs change while the clock is low, and the controller samples its inputs at the rising edge. The serial clock runs at a fixed division of the system clock.

Top module: `dspi_read_ctrl`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, both output enables are 0, and `busy`, `done`, `dout_valid` and `cont_mode` are all 0.
- R2: When `cont_mode` is 0, a read frame opens with 8 serial clocks that carry the command byte 0xBB MSB first on `io0_o`. During these clocks `io0_oe` is 1 and `io1_oe` is 0.
- R3: Next come ADDR_W/2 clocks (12 by default) with both enables at 1. Each clock carries one address pair, highest pair first, with the odd bit on `io1_o` and the even bit on `io0_o`.
- R4: Next come 4 clocks with both enables at 1 that carry the mode byte, pair {M7,M6} first and with the same odd/even split. The byte is 0x20 (M5..M4 = 10) when `cont_en` was 1 at the request, and 0x00 otherwise.
- R5: Both output enables fall at the falling serial edge that ends the last mode clock. They stay at 0 for the whole data phase.
- R6: In the data phase each byte takes 4 clocks, MSB pair first, with the odd bit read from `io1_i`. The controller samples at each rising edge. Every byte appears on `dout` with a one-cycle `dout_valid`, and bytes arrive in address order.
- R7: A read of N bytes takes exactly N*4 data clocks. After them `cs_n` returns to 1, and then `done` pulses for exactly one cycle.
- R8: `cont_mode` takes the `cont_en` value of the most recent read. While `cont_mode` is 1, a read frame leaves out the command phase, so 16 clocks come before the data phase.
- R9: An exit request runs a frame of exactly 8 clocks with both lines driven to 1 and both enables at 1. The frame has no data phase. After it, `done` pulses and `cont_mode` is 0.
- R10: `sclk` is 0 whenever `cs_n` is 1, and `sclk` rises only while `cs_n` is 0. Data outputs and enables change only while `sclk` is 0. While `cs_n` is 1, both enables are 0.
- R11: Between frames, `cs_n` stays 1 for at least 2 system clocks.
- R12: The controller accepts requests only while `busy` is 0. A `req` that arrives while busy is ignored. A `req` with `req_len` of 0 is ignored. If `exit_req` and `req` arrive in the same idle cycle, the exit runs and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, sampled while idle |
| req_addr | input | ADDR_W | Start address of the read |
| req_len | input | LEN_W | Number of bytes to read (0 means no transaction) |
| cont_en | input | 1 | Ask the flash to accept address-first frames next |
| exit_req | input | 1 | Run a mode-exit frame |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| dout | output | 8 | Received byte |
| dout_valid | output | 1 | `dout` holds a new byte |
| cont_mode | output | 1 | The flash is in address-first mode |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| io0_o | output | 1 | Line 0 output value |
| io0_oe | output | 1 | Line 0 output enable |
| io0_i | input | 1 | Line 0 input value |
| io1_o | output | 1 | Line 1 output value |
| io1_oe | output | 1 | Line 1 output enable |
| io1_i | input | 1 | Line 1 input value |

## Verification
The checks assume that the flash-side inputs settle during the low half of the serial clock and that the user holds a request for only one cycle. The bench's flash model drives `io0_i`/`io1_i` only in the system cycle after it sees a falling serial edge. It releases nothing itself. The bench always pulses `req` and `exit_req` for one cycle, except in the R12 cases, which deliberately collide a request with a busy controller or with an exit.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEND,
      ST_RECV,
      ST_GAP
   } dspi_state_e;

   localparam int OPC_PAIRS      = 8;
   localparam int MODE_PAIRS     = 4;
   localparam int EXIT_PAIRS     = 8;
   localparam int PAIRS_PER_BYTE = 4;

   localparam logic [7:0] MODE_STAY = 8'h20;
   localparam logic [7:0] MODE_DROP = 8'h00;

endpackage

// File: rtl/dspi_tick.sv
module dspi_tick #(
   parameter int DIV_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [CW-1:0] CMAX = CW'(DIV_HALF - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt == CMAX) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == CMAX);
endmodule

// File: rtl/dspi_txshift.sv
module dspi_txshift import dspi_pkg::*; #(
   parameter int         ADDR_W = 24,
   parameter logic [7:0] OPCODE = 8'hBB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              with_opc,
   input  logic              keep_mode,
   input  logic              exit_sel,
   input  logic [ADDR_W-1:0] addr,
   output logic [1:0]        pair,
   output logic              io1_en,
   output logic              last
);
   localparam int FP = OPC_PAIRS + ADDR_W / 2 + MODE_PAIRS;
   localparam int VW = 2 * FP;
   localparam int CW = $clog2(FP + 1);

   logic [2*OPC_PAIRS-1:0] opc_il;
   logic [7:0]             mode_byte;
   logic [VW-1:0]          ld_vec, sr;
   logic [FP-1:0]          ld_msk, msk;
   logic [CW-1:0]          ld_len, left;

   // command bits ride on line 0 only; line 1 slot held at zero
   for (genvar gi = 0; gi < OPC_PAIRS; gi++) begin : g_opc
      assign opc_il[2*gi+1] = 1'b0;
      assign opc_il[2*gi]   = OPCODE[gi];
   end

   assign mode_byte = keep_mode ? MODE_STAY : MODE_DROP;

   always_comb begin
      if (exit_sel) begin
         ld_vec = {{(2*EXIT_PAIRS){1'b1}}, {(VW-2*EXIT_PAIRS){1'b0}}};
         ld_msk = '1;
         ld_len = CW'(EXIT_PAIRS);
      end else if (with_opc) begin
         ld_vec = {opc_il, addr, mode_byte};
         ld_msk = {{OPC_PAIRS{1'b0}}, {(FP-OPC_PAIRS){1'b1}}};
         ld_len = CW'(FP);
      end else begin
         ld_vec = {addr, mode_byte, {(2*OPC_PAIRS){1'b0}}};
         ld_msk = '1;
         ld_len = CW'(FP - OPC_PAIRS);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         msk  <= '0;
         left <= '0;
      end else if (load) begin
         sr   <= ld_vec;
         msk  <= ld_msk;
         left <= ld_len;
      end else if (shift) begin
         sr   <= {sr[VW-3:0], 2'b00};
         msk  <= {msk[FP-2:0], 1'b0};
         left <= left - 1'b1;
      end
   end

   assign pair   = sr[VW-1 -: 2];
   assign io1_en = msk[FP-1];
   assign last   = (left == CW'(1));
endmodule

// File: rtl/dspi_rxbyte.sv
module dspi_rxbyte import dspi_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       sample,
   input  logic [1:0] pair_in,
   output logic [7:0] data,
   output logic       valid
);
   localparam logic [1:0] LAST_PAIR = 2'(PAIRS_PER_BYTE - 1);

   logic [1:0] cnt;
   logic [5:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sh    <= '0;
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (clear) begin
            cnt <= '0;
            sh  <= '0;
         end else if (sample) begin
            sh  <= {sh[3:0], pair_in};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_PAIR) begin
               valid <= 1'b1;
               data  <= {sh, pair_in};
            end
         end
      end
   end
endmodule

// File: rtl/dspi_seq.sv
module dspi_seq import dspi_pkg::*; #(
   parameter int LEN_W  = 8,
   parameter int CS_GAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [LEN_W-1:0] req_len,
   input  logic             cont_en,
   input  logic             exit_req,
   input  logic             tick,
   input  logic             tx_last,
   output logic             busy,
   output logic             done,
   output logic             cont_mode,
   output logic             cs_n,
   output logic             sclk,
   output logic             tx_load,
   output logic             tx_shift,
   output logic             tx_with_opc,
   output logic             send_phase,
   output logic             rx_sample,
   output logic             clk_en
);
   localparam int DCW = LEN_W + 2;
   localparam int GW  = $clog2(CS_GAP);

   dspi_state_e     state;
   logic [DCW-1:0]  dclk_left;
   logic [GW-1:0]   gap_cnt;
   logic            exit_lat, keep_lat;

   assign tx_load     = (state == ST_IDLE) && (exit_req || (req && (req_len != '0)));
   assign tx_with_opc = !cont_mode;
   assign tx_shift    = (state == ST_SEND) && tick && sclk;
   assign rx_sample   = (state == ST_RECV) && tick && !sclk;
   assign send_phase  = (state == ST_SEND);
   assign clk_en      = (state == ST_SEND) || (state == ST_RECV);
   assign busy        = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cs_n      <= 1'b1;
         sclk      <= 1'b0;
         done      <= 1'b0;
         cont_mode <= 1'b0;
         dclk_left <= '0;
         gap_cnt   <= '0;
         exit_lat  <= 1'b0;
         keep_lat  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (tx_load) begin
               cs_n      <= 1'b0;
               state     <= ST_SEND;
               exit_lat  <= exit_req;
               keep_lat  <= cont_en & ~exit_req;
               dclk_left <= {req_len, 2'b00};
            end
            ST_SEND: if (tick) begin
               if (!sclk) sclk <= 1'b1;
               else begin
                  sclk <= 1'b0;
                  if (tx_last) begin
                     if (exit_lat) begin
                        cs_n    <= 1'b1;
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                     end else begin
                        state <= ST_RECV;
                     end
                  end
               end
            end
            ST_RECV: if (tick) begin
               if (!sclk) sclk <= 1'b1;
               else begin
                  sclk      <= 1'b0;
                  dclk_left <= dclk_left - 1'b1;
                  if (dclk_left == DCW'(1)) begin
                     cs_n    <= 1'b1;
                     gap_cnt <= '0;
                     state   <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               if (gap_cnt == GW'(CS_GAP - 1)) begin
                  state     <= ST_IDLE;
                  done      <= 1'b1;
                  cont_mode <= keep_lat;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dspi_read_ctrl.sv
module dspi_read_ctrl #(
   parameter int         ADDR_W   = 24,
   parameter int         LEN_W    = 8,
   parameter int         DIV_HALF = 2,
   parameter int         CS_GAP   = 2,
   parameter logic [7:0] OPCODE   = 8'hBB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              cont_en,
   input  logic              exit_req,
   output logic              busy,
   output logic              done,
   output logic [7:0]        dout,
   output logic              dout_valid,
   output logic              cont_mode,
   output logic              cs_n,
   output logic              sclk,
   output logic              io0_o,
   output logic              io0_oe,
   input  logic              io0_i,
   output logic              io1_o,
   output logic              io1_oe,
   input  logic              io1_i
);
   if ((ADDR_W % 2) != 0 || ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be even and at least 8");
   end
   if (CS_GAP < 2) begin : g_bad_gap
      $error("CS_GAP must be at least 2");
   end
   if (DIV_HALF < 1) begin : g_bad_div
      $error("DIV_HALF must be at least 1");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("LEN_W must be at least 1");
   end

   logic       tick, clk_en, tx_load, tx_shift, tx_with_opc, tx_last;
   logic       tx_io1_en, send_phase, rx_sample;
   logic [1:0] tx_pair;

   dspi_tick #(.DIV_HALF(DIV_HALF)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(clk_en), .tick(tick)
   );

   dspi_seq #(.LEN_W(LEN_W), .CS_GAP(CS_GAP)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_len(req_len),
      .cont_en(cont_en), .exit_req(exit_req), .tick(tick), .tx_last(tx_last),
      .busy(busy), .done(done), .cont_mode(cont_mode), .cs_n(cs_n), .sclk(sclk),
      .tx_load(tx_load), .tx_shift(tx_shift), .tx_with_opc(tx_with_opc),
      .send_phase(send_phase), .rx_sample(rx_sample), .clk_en(clk_en)
   );

   dspi_txshift #(.ADDR_W(ADDR_W), .OPCODE(OPCODE)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(tx_shift),
      .with_opc(tx_with_opc), .keep_mode(cont_en), .exit_sel(exit_req),
      .addr(req_addr), .pair(tx_pair), .io1_en(tx_io1_en), .last(tx_last)
   );

   dspi_rxbyte u_rx (
      .clk(clk), .rst_n(rst_n), .clear(tx_load), .sample(rx_sample),
      .pair_in({io1_i, io0_i}), .data(dout), .valid(dout_valid)
   );

   assign io0_o  = tx_pair[0];
   assign io1_o  = tx_pair[1];
   assign io0_oe = send_phase;
   assign io1_oe = send_phase & tx_io1_en;
endmodule

// File: rtl/dspi_read_ctrl_chk.sv
module dspi_read_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic dout_valid,
   input logic cs_n,
   input logic sclk,
   input logic io0_o,
   input logic io0_oe,
   input logic io1_o,
   input logic io1_oe
);
   assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!sclk && !io0_oe && !io1_oe));

   assert_sclk_rise_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> !cs_n);

   assert_change_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(io0_o) || !$stable(io1_o) || !$stable(io0_oe) || !$stable(io1_oe)) |-> !sclk);

   assert_line1_needs_line0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      io1_oe |-> io0_oe);

   assert_valid_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> !cs_n);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_cs_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);

   assert_idle_deselect_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);
endmodule

bind dspi_read_ctrl dspi_read_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .dout_valid(dout_valid),
   .cs_n(cs_n), .sclk(sclk), .io0_o(io0_o), .io0_oe(io0_oe),
   .io1_o(io1_o), .io1_oe(io1_oe)
);

// File: tb/tb_dspi_read_ctrl.sv
module tb_dspi_read_ctrl;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, req, cont_en, exit_req, io0_i, io1_i;
   logic [23:0] req_addr;
   logic [7:0]  req_len;
   logic        busy, done, dout_valid, cont_mode, cs_n, sclk;
   logic        io0_o, io0_oe, io1_o, io1_oe;
   logic [7:0]  dout;

   dspi_read_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_len(req_len),
      .cont_en(cont_en), .exit_req(exit_req), .busy(busy), .done(done),
      .dout(dout), .dout_valid(dout_valid), .cont_mode(cont_mode), .cs_n(cs_n),
      .sclk(sclk), .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(io0_i),
      .io1_o(io1_o), .io1_oe(io1_oe), .io1_i(io1_i)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mem_byte(input logic [23:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
   endfunction

   // expectation for the next frame, set by the tasks
   int          exp_kind = 0;   // 0 read, 1 exit
   int          exp_skip = 0;
   int          exp_cont = 0;
   int          exp_len  = 0;
   logic [23:0] exp_addr = '0;
   logic [7:0]  exp_q[$];
   bit          model_mode = 1'b0;
   int          frames = 0;

   // behavioural flash model, checked every system clock
   initial begin
      int    send_len, rise_cnt, hi_cnt, j, n;
      int    epair[32];
      int    eoe1[32];
      string etag[32];
      bit    pcs, psclk;
      logic [7:0] d, m, e;
      send_len = 0; rise_cnt = 0; hi_cnt = 100; pcs = 1'b1; psclk = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (pcs && !cs_n) begin
               frames++;
               chk(hi_cnt >= 2, "R11", hi_cnt, 2);
               n = 0;
               if (exp_kind == 1) begin
                  for (int i = 0; i < 8; i++) begin
                     epair[n] = 3; eoe1[n] = 1; etag[n] = "R9"; n++;
                  end
               end else begin
                  if (exp_skip == 0) begin
                     for (int i = 0; i < 8; i++) begin
                        epair[n] = (8'hBB >> (7 - i)) & 1; eoe1[n] = 0; etag[n] = "R2"; n++;
                     end
                  end
                  for (int k = 0; k < 12; k++) begin
                     epair[n] = int'((exp_addr >> (22 - 2*k)) & 24'd3);
                     eoe1[n] = 1; etag[n] = (exp_skip != 0) ? "R8" : "R3"; n++;
                  end
                  m = (exp_cont != 0) ? 8'h20 : 8'h00;
                  for (int k = 0; k < 4; k++) begin
                     epair[n] = int'((m >> (6 - 2*k)) & 8'd3); eoe1[n] = 1; etag[n] = "R4"; n++;
                  end
               end
               send_len = n;
               rise_cnt = 0;
            end
            if (cs_n) begin
               hi_cnt++;
               chk(!sclk && !io0_oe && !io1_oe, "R10", {sclk, io0_oe, io1_oe}, 0);
            end else begin
               hi_cnt = 0;
            end
            if (!cs_n && !psclk && sclk) begin
               if (rise_cnt < send_len) begin
                  chk(io0_oe && (io1_oe == eoe1[rise_cnt][0]), etag[rise_cnt],
                      {io0_oe, io1_oe}, {1'b1, eoe1[rise_cnt][0]});
                  chk((io0_o == epair[rise_cnt][0]) &&
                      (eoe1[rise_cnt] == 0 || io1_o == epair[rise_cnt][1]),
                      etag[rise_cnt], {io1_o, io0_o}, epair[rise_cnt]);
               end else begin
                  chk(!io0_oe && !io1_oe, "R5", {io0_oe, io1_oe}, 0);
               end
               rise_cnt++;
            end
            if (!cs_n && psclk && !sclk && rise_cnt >= send_len) begin
               j = rise_cnt - send_len;
               if (j / 4 < exp_len) begin
                  d = mem_byte(exp_addr + 24'(j / 4));
                  io1_i = d[7 - 2*(j % 4)];
                  io0_i = d[6 - 2*(j % 4)];
               end
            end
            if (!pcs && cs_n)
               chk(rise_cnt == send_len + 4*exp_len, "R7", rise_cnt, send_len + 4*exp_len);
            if (dout_valid) begin
               if (exp_q.size() == 0) chk(1'b0, "R6", dout, 0);
               else begin
                  e = exp_q.pop_front();
                  chk(dout == e, "R6", dout, e);
               end
            end
         end
         pcs = cs_n;
         psclk = sclk;
      end
   end

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic wait_done(input bit newmode, input string tag);
      while (!done) @(negedge clk);
      chk(cont_mode == newmode, tag, cont_mode, newmode);
      chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
      model_mode = newmode;
      @(negedge clk);
      chk(!done, "R7", done, 0);
   endtask

   task automatic start_read(input logic [23:0] a, input int len, input bit cont);
      wait_idle();
      exp_kind = 0; exp_skip = model_mode; exp_addr = a; exp_len = len; exp_cont = cont;
      for (int i = 0; i < len; i++) exp_q.push_back(mem_byte(a + 24'(i)));
      req_addr = a; req_len = 8'(len); cont_en = cont; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic do_read(input logic [23:0] a, input int len, input bit cont);
      start_read(a, len, cont);
      wait_done(cont, "R8");
   endtask

   task automatic do_exit();
      wait_idle();
      exp_kind = 1; exp_len = 0;
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      wait_done(1'b0, "R9");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL R7 watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int f0;
      rst_n = 1'b0; req = 1'b0; cont_en = 1'b0; exit_req = 1'b0;
      io0_i = 1'b0; io1_i = 1'b0; req_addr = '0; req_len = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n && !sclk && !io0_oe && !io1_oe, "R1", {cs_n, sclk, io0_oe, io1_oe}, 8);
      chk(!busy && !done && !dout_valid && !cont_mode, "R1",
          {busy, done, dout_valid, cont_mode}, 0);

      do_read(24'h123456, 4, 1'b0);   // full frame, drop value
      do_read(24'hABCDEF, 1, 1'b1);   // full frame, stay value
      do_read(24'h00FFFE, 3, 1'b1);   // address-first frame
      do_read(24'h7FFFFF, 2, 1'b0);   // address-first, leave mode
      do_read(24'h000001, 1, 1'b0);   // back to full frame
      do_read(24'hC3A55A, 16, 1'b1);
      do_exit();
      chk(cont_mode == 1'b0, "R9", cont_mode, 0);
      do_read(24'h5A5A5A, 2, 1'b0);   // must carry command again
      do_read(24'hFFFF00, 255, 1'b0); // longest count

      // R12: request while busy is ignored
      wait_idle();
      f0 = frames;
      start_read(24'h000100, 2, 1'b0);
      repeat (6) @(negedge clk);
      chk(busy, "R12", busy, 1);
      req_addr = 24'h999999; req_len = 8'd5; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      wait_done(1'b0, "R12");
      repeat (6) @(negedge clk);
      chk(frames == f0 + 1, "R12", frames - f0, 1);

      // R12: zero length is ignored
      f0 = frames;
      req_len = 8'd0; req_addr = 24'h010203; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      repeat (20) @(negedge clk);
      chk(frames == f0 && cs_n && !busy, "R12", frames - f0, 0);

      // R12: exit wins over a same-cycle read
      do_read(24'h300000, 1, 1'b1);
      wait_idle();
      f0 = frames;
      exp_kind = 1; exp_len = 0;
      req_addr = 24'h222222; req_len = 8'd3; cont_en = 1'b1;
      req = 1'b1; exit_req = 1'b1;
      @(negedge clk);
      req = 1'b0; exit_req = 1'b0;
      wait_done(1'b0, "R12");
      repeat (6) @(negedge clk);
      chk(frames == f0 + 1, "R12", frames - f0, 1);
      do_read(24'h0A0B0C, 2, 1'b0);

      repeat (10) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule